// File: doc/BRIEF.md
# Double-to-signed-integer converter

The block takes an IEEE-754 double-precision operand and turns it into a two's-complement signed integer of either 32 or 64 bits. The integer is rounded under a 2-bit rounding-control input. Values that cannot be represented give a fixed "integer indefinite" pattern. Flags report invalid and inexact conversions, and a separate flag reports an encoding fault.

A request is presented with `in_valid`. The result, the write-enable and the flags appear one clock later with `out_valid`. The surrounding pipeline uses `wr_en` to decide whether the destination register is written. It uses the flags for its own exception handling.

An encoding-check field must be all ones for the operation to be legal. If it is not, no write takes place and only the encoding fault is reported.

Top module: `dbl2int_cvt`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by one clock. Whenever `out_valid` is low, `wr_en`, `flag_inv`, `flag_inx` and `flag_ud` are low and `result` is zero. Reset clears every output.
- R2: A value that is already integral converts exactly. With `wide`=1 the full 64-bit two's-complement value is returned. With `wide`=0 the 32-bit two's-complement value is placed in `result[31:0]` and `result[63:32]` is zero.
- R3: A non-integral value is rounded according to `rmode`: 2'b00 to nearest with ties to even, 2'b01 toward minus infinity, 2'b10 toward plus infinity, 2'b11 toward zero.
- R4: `flag_inx` is 1 exactly when nonzero fraction bits are discarded on a valid conversion, subnormal inputs included. A subnormal input gives 0, except for two cases: a negative subnormal gives -1 when rounding toward minus infinity, and a positive subnormal gives +1 when rounding toward plus infinity.
- R5: A rounded value outside the signed range of the selected width raises `flag_inv`. A value that rounds to exactly the most negative integer of the width is valid.
- R6: Quiet NaN, signalling NaN, +infinity and -infinity all raise `flag_inv`.
- R7: On an invalid conversion with `inv_mask`=1, `wr_en`=1 and `flag_inx`=0. The result is the indefinite pattern: 64'h0000_0000_8000_0000 for 32-bit width and 64'h8000_0000_0000_0000 for 64-bit width.
- R8: On an invalid conversion with `inv_mask`=0, `flag_inv`=1, `wr_en`=0 and `result` is zero.
- R9: When `enc_chk` is not 4'b1111, `flag_ud`=1, `wr_en`=0, `flag_inv`=0, `flag_inx`=0 and `result` is zero, whatever the operand.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| in_op | input | 64 | Double-precision operand |
| wide | input | 1 | 1: 64-bit result, 0: 32-bit result |
| rmode | input | 2 | Rounding control |
| inv_mask | input | 1 | 1: invalid exception masked |
| enc_chk | input | 4 | Encoding-check field; legal only as 4'b1111 |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| result | output | 64 | Converted integer |
| wr_en | output | 1 | Destination write-enable |
| flag_inv | output | 1 | Invalid conversion |
| flag_inx | output | 1 | Inexact conversion |
| flag_ud | output | 1 | Illegal encoding |

## Verification
The bench sweeps quarter-step values in both widths under every rounding mode. This catches a design that breaks ties away from zero, or that rounds negative values on the magnitude in the wrong direction. It also walks across the 32-bit range edge on both signs, where an off-by-one limit would reject the most negative integer or accept 2^31. Directed cases cover the remaining corners:
- subnormals, which a design without a sticky bit would report as exact or fail to round to ±1;
- NaN and infinity, which a design ignoring the all-ones exponent would convert to garbage;
- 2^63 and -2^63 in 64-bit width;
- unmasked invalid and bad encodings, which a faulty design would still write.

// File: rtl/dbl2int_cvt.sv
`timescale 1ns/1ps
module dbl2int_cvt (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [63:0] in_op,
  input  logic        wide,
  input  logic [1:0]  rmode,
  input  logic        inv_mask,
  input  logic [3:0]  enc_chk,
  output logic        out_valid,
  output logic [63:0] result,
  output logic        wr_en,
  output logic        flag_inv,
  output logic        flag_inx,
  output logic        flag_ud
);
  localparam int unsigned EXP_W  = 11;
  localparam int unsigned FRAC_W = 52;
  localparam logic [EXP_W-1:0] E_FIX  = 11'd1011;
  localparam logic [EXP_W-1:0] E_HUGE = 11'd1087;

  logic              sgn;
  logic [EXP_W-1:0]  ex;
  logic [FRAC_W-1:0] fr;
  assign {sgn, ex, fr} = in_op;

  wire special = &ex;
  wire tiny    = ex < E_FIX;
  wire huge    = ex >= E_HUGE;

  logic [6:0]   sh;
  logic [127:0] fx;
  assign sh = 7'(ex - E_FIX);
  assign fx = {75'd0, 1'b1, fr} << sh;

  logic [63:0] ipart;
  logic        guard, sticky, inc;
  assign ipart  = tiny ? 64'd0 : fx[127:64];
  assign guard  = tiny ? 1'b0 : fx[63];
  assign sticky = tiny ? (|in_op[62:0]) : (|fx[62:0]);

  always_comb begin
    case (rmode)
      2'b00:   inc = guard & (sticky | ipart[0]);
      2'b01:   inc = sgn & (guard | sticky);
      2'b10:   inc = ~sgn & (guard | sticky);
      default: inc = 1'b0;
    endcase
  end

  logic [64:0] mag, lim;
  assign mag = {1'b0, ipart} + {64'd0, inc};
  assign lim = (wide ? (65'd1 << 63) : (65'd1 << 31)) - {64'd0, ~sgn};

  wire inv = special | huge | (mag > lim);
  wire ud  = enc_chk != 4'hF;
  wire we  = ~ud & (~inv | inv_mask);

  logic [63:0] sres, val, indef, res_d;
  assign sres  = sgn ? (64'd0 - mag[63:0]) : mag[63:0];
  assign val   = wide ? sres : {32'd0, sres[31:0]};
  assign indef = wide ? 64'h8000_0000_0000_0000 : 64'h0000_0000_8000_0000;
  assign res_d = !we ? 64'd0 : (inv ? indef : val);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      wr_en     <= 1'b0;
      flag_inv  <= 1'b0;
      flag_inx  <= 1'b0;
      flag_ud   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      result    <= in_valid ? res_d : 64'd0;
      wr_en     <= in_valid & we;
      flag_inv  <= in_valid & ~ud & inv;
      flag_inx  <= in_valid & ~ud & ~inv & (guard | sticky);
      flag_ud   <= in_valid & ud;
    end
  end
endmodule

// File: rtl/dbl2int_cvt_chk.sv
`timescale 1ns/1ps
module dbl2int_cvt_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        wide,
  input logic        inv_mask,
  input logic        out_valid,
  input logic [63:0] result,
  input logic        wr_en,
  input logic        flag_inv,
  input logic        flag_inx,
  input logic        flag_ud
);
  p_valid_pipe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!wr_en && !flag_inv && !flag_inx && !flag_ud && result == 64'd0));
  p_narrow_upper_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && wr_en && !$past(wide)) |-> result[63:32] == 32'd0);
  p_indef_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_inv && wr_en) |-> (!flag_inx &&
      (result == 64'h0000_0000_8000_0000 || result == 64'h8000_0000_0000_0000)));
  p_unmasked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && flag_inv && !wr_en) |-> (!$past(inv_mask) && result == 64'd0));
  p_ud_nowrite_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flag_ud |-> (!wr_en && !flag_inv && !flag_inx && result == 64'd0));
endmodule

bind dbl2int_cvt dbl2int_cvt_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .wide(wide),
  .inv_mask(inv_mask), .out_valid(out_valid), .result(result),
  .wr_en(wr_en), .flag_inv(flag_inv), .flag_inx(flag_inx), .flag_ud(flag_ud)
);

// File: tb/dbl2int_cvt_tb.sv
`timescale 1ns/1ps
module dbl2int_cvt_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0, in_valid = 1'b0, wide = 1'b0, inv_mask = 1'b1;
  logic [63:0] in_op = '0;
  logic [1:0]  rmode = 2'b00;
  logic [3:0]  enc_chk = 4'hF;
  logic        out_valid, wr_en, flag_inv, flag_inx, flag_ud;
  logic [63:0] result;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  dbl2int_cvt u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op), .wide(wide),
    .rmode(rmode), .inv_mask(inv_mask), .enc_chk(enc_chk), .out_valid(out_valid),
    .result(result), .wr_en(wr_en), .flag_inv(flag_inv), .flag_inx(flag_inx),
    .flag_ud(flag_ud)
  );

  task automatic expect_out(string tag, bit ev, logic [63:0] er, bit ewe, bit einv, bit einx, bit eud);
    logic [4:0] af, ef;
    af = {out_valid, wr_en, flag_inv, flag_inx, flag_ud};
    ef = {ev, ewe, einv, einx, eud};
    checks++;
    if (af !== ef || result !== er) begin
      errors++;
      $display("FAIL %s op=%h w=%0b rm=%0d: actual res=%h v/we/inv/inx/ud=%b expected res=%h %b",
               tag, in_op, wide, rmode, result, af, er, ef);
    end
  endtask

  task automatic apply(logic [63:0] op, bit w, logic [1:0] rm, bit m, logic [3:0] e);
    @(negedge clk);
    in_op = op; wide = w; rmode = rm; inv_mask = m; enc_chk = e; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_q(string tag, longint q, bit w, logic [1:0] rm);
    longint fl, r;
    longint rem;
    bit inx, bad;
    logic [63:0] er;
    fl  = q >>> 2;
    rem = q & 64'sd3;
    inx = rem != 0;
    case (rm)
      2'b00: r = (rem < 2) ? fl : (rem > 2) ? fl + 1 : fl + (fl & 64'sd1);
      2'b01: r = fl;
      2'b10: r = inx ? fl + 1 : fl;
      default: r = (q < 0 && inx) ? fl + 1 : fl;
    endcase
    bad = !w && (r > 64'sd2147483647 || r < -64'sd2147483648);
    if (bad) er = 64'h0000_0000_8000_0000;
    else if (w) er = r;
    else er = {32'd0, r[31:0]};
    apply($realtobits($itor(q) / 4.0), w, rm, 1'b1, 4'hF);
    expect_out(tag, 1'b1, er, 1'b1, bad, bad ? 1'b0 : inx, 1'b0);
  endtask

  localparam logic [63:0] QNAN  = 64'h7FF8_0000_0000_0000;
  localparam logic [63:0] SNAN  = 64'h7FF0_0000_0000_0001;
  localparam logic [63:0] PINF  = 64'h7FF0_0000_0000_0000;
  localparam logic [63:0] NINF  = 64'hFFF0_0000_0000_0000;
  localparam logic [63:0] P2_63 = 64'h43E0_0000_0000_0000;
  localparam logic [63:0] N2_63 = 64'hC3E0_0000_0000_0000;
  localparam logic [63:0] BELOW = 64'h43DF_FFFF_FFFF_FFFF;
  localparam logic [63:0] P2_31 = 64'h41E0_0000_0000_0000;
  localparam logic [63:0] IND32 = 64'h0000_0000_8000_0000;
  localparam logic [63:0] IND64 = 64'h8000_0000_0000_0000;

  initial begin
    repeat (3) @(negedge clk);
    expect_out("R1 reset", 1'b0, 64'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    expect_out("R1 idle", 1'b0, 64'd0, 1'b0, 1'b0, 1'b0, 1'b0);

    for (int w = 0; w < 2; w++)
      for (int rm = 0; rm < 4; rm++)
        for (longint q = -40; q <= 40; q++)
          run_q(((q & 3) == 0) ? "R2 exact" : "R3 round", q, w[0], rm[1:0]);

    for (int rm = 0; rm < 4; rm++)
      for (longint d = -12; d <= 12; d++) begin
        run_q("R5 upper edge", 64'sd8589934592 + d, 1'b0, rm[1:0]);
        run_q("R5 lower edge", -64'sd8589934592 + d, 1'b0, rm[1:0]);
      end

    apply(64'h0000_0000_0000_0001, 1'b0, 2'b00, 1'b1, 4'hF);
    expect_out("R4 denorm rne", 1'b1, 64'd0, 1'b1, 1'b0, 1'b1, 1'b0);
    apply(64'h0000_0000_0000_0001, 1'b0, 2'b10, 1'b1, 4'hF);
    expect_out("R4 denorm up", 1'b1, 64'd1, 1'b1, 1'b0, 1'b1, 1'b0);
    apply(64'h0000_0000_0000_0001, 1'b0, 2'b01, 1'b1, 4'hF);
    expect_out("R4 denorm down", 1'b1, 64'd0, 1'b1, 1'b0, 1'b1, 1'b0);
    apply(64'h800F_FFFF_FFFF_FFFF, 1'b0, 2'b01, 1'b1, 4'hF);
    expect_out("R4 neg denorm down", 1'b1, 64'h0000_0000_FFFF_FFFF, 1'b1, 1'b0, 1'b1, 1'b0);
    apply(64'h800F_FFFF_FFFF_FFFF, 1'b1, 2'b10, 1'b1, 4'hF);
    expect_out("R4 neg denorm up", 1'b1, 64'd0, 1'b1, 1'b0, 1'b1, 1'b0);
    apply(64'h8000_0000_0000_0000, 1'b1, 2'b01, 1'b1, 4'hF);
    expect_out("R4 neg zero", 1'b1, 64'd0, 1'b1, 1'b0, 1'b0, 1'b0);

    apply(P2_63, 1'b1, 2'b00, 1'b1, 4'hF);
    expect_out("R5 2^63", 1'b1, IND64, 1'b1, 1'b1, 1'b0, 1'b0);
    apply(N2_63, 1'b1, 2'b00, 1'b1, 4'hF);
    expect_out("R5 -2^63", 1'b1, IND64, 1'b1, 1'b0, 1'b0, 1'b0);
    apply(BELOW, 1'b1, 2'b11, 1'b1, 4'hF);
    expect_out("R5 max64", 1'b1, 64'h7FFF_FFFF_FFFF_FC00, 1'b1, 1'b0, 1'b0, 1'b0);
    apply(P2_31, 1'b1, 2'b00, 1'b1, 4'hF);
    expect_out("R2 2^31 wide", 1'b1, 64'h0000_0000_8000_0000, 1'b1, 1'b0, 1'b0, 1'b0);
    apply(64'h7E37_E43C_8800_759C, 1'b0, 2'b11, 1'b1, 4'hF);
    expect_out("R5 huge", 1'b1, IND32, 1'b1, 1'b1, 1'b0, 1'b0);

    apply(QNAN, 1'b0, 2'b00, 1'b1, 4'hF);
    expect_out("R6 qnan", 1'b1, IND32, 1'b1, 1'b1, 1'b0, 1'b0);
    apply(SNAN, 1'b1, 2'b01, 1'b1, 4'hF);
    expect_out("R6 snan", 1'b1, IND64, 1'b1, 1'b1, 1'b0, 1'b0);
    apply(PINF, 1'b0, 2'b10, 1'b1, 4'hF);
    expect_out("R6 +inf", 1'b1, IND32, 1'b1, 1'b1, 1'b0, 1'b0);
    apply(NINF, 1'b1, 2'b11, 1'b1, 4'hF);
    expect_out("R7 -inf wide", 1'b1, IND64, 1'b1, 1'b1, 1'b0, 1'b0);

    apply(QNAN, 1'b1, 2'b00, 1'b0, 4'hF);
    expect_out("R8 unmasked nan", 1'b1, 64'd0, 1'b0, 1'b1, 1'b0, 1'b0);
    apply(P2_31, 1'b0, 2'b00, 1'b0, 4'hF);
    expect_out("R8 unmasked ovf", 1'b1, 64'd0, 1'b0, 1'b1, 1'b0, 1'b0);
    apply($realtobits(-7.25), 1'b0, 2'b00, 1'b0, 4'hF);
    expect_out("R8 mask unused", 1'b1, 64'h0000_0000_FFFF_FFF9, 1'b1, 1'b0, 1'b1, 1'b0);

    apply($realtobits(3.5), 1'b0, 2'b00, 1'b1, 4'b0111);
    expect_out("R9 ud", 1'b1, 64'd0, 1'b0, 1'b0, 1'b0, 1'b1);
    apply(QNAN, 1'b1, 2'b00, 1'b1, 4'b1110);
    expect_out("R9 ud nan", 1'b1, 64'd0, 1'b0, 1'b0, 1'b0, 1'b1);
    apply($realtobits(5.0), 1'b1, 2'b00, 1'b1, 4'h0);
    expect_out("R9 ud zero field", 1'b1, 64'd0, 1'b0, 1'b0, 1'b0, 1'b1);

    @(negedge clk);
    expect_out("R1 drop", 1'b0, 64'd0, 1'b0, 1'b0, 1'b0, 1'b0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule